// File: doc/BRIEF.md
# Serial Clock-Chip Register Access Controller

This block is the serial slave front end of a timekeeping chip. A host drives a four-wire serial link: an active-low chip select, a serial clock that idles low, a data input sampled on the clock's rising edge, and a data output that changes on the falling edge. The block samples all three link wires into its own system clock domain. It decodes the command byte that opens every transfer, then moves data bytes between the link and three targets. These are a 31-byte scratch RAM, the timekeeping counters, and an external register port that serves the remaining registers, such as the alarm thresholds.

The block never writes straight into the timekeeping counters. Written time values collect in a staging buffer. They are handed to the counters in one load pulse, and only after chip select rises at the end of a transfer that delivered every byte it needed. Reads of the time work the other way: the counters are copied into a snapshot once the read command is in. The copy is delayed while a seconds increment is in progress, and the whole transfer is then served from the snapshot while the counters keep running. A write-protect flag in the control register locks every other write path.

Top module: `rtc_spi_regs`

## Requirements
- R1: Bits shift MSB first. Input bits are sampled on rising `sclk`. Output bits change on falling `sclk`, and the first data byte appears on the falling edge after the command's eighth rising edge. While `cs_n` is high, `miso` and `miso_oe` are both 0. While `cs_n` is low, `miso_oe` is 1.
- R2: Command bit 0 must be 1 for any write. If it is 0, no RAM location, staged time value, control bit or external register is written.
- R3: Command 3Fh is a clock burst write. Its eight data bytes go to seconds, minutes, hours, date, month, day of week, year and control, in that order. A single `tk_load` pulse with mask 7Fh is issued after `cs_n` rises, but only if all eight bytes arrived and no partial byte followed. Otherwise nothing is loaded.
- R4: Command BFh is a clock burst read. It returns the snapshot bytes seconds through year, then the control byte, then zeros.
- R5: The snapshot of `tk_cur` is taken after a read command byte to register space. It is never taken in a cycle where `tk_inc` is high. Changes to `tk_cur` after the snapshot do not alter the data read out.
- R6: `tk_load` is never high while `tk_inc` is high. A pending load waits until `tk_inc` is low.
- R7: A single write to a timekeeping register is staged and loaded after `cs_n` rises, only if its data byte completed and no partial byte followed. The register command is {0,0,a[4:0],1}, with seconds through year at a = 0..6 and century at a = 9. The load lane is byte i of `tk_load_data`, where i = a for a ≤ 6 and i = 7 for century, with only mask bit i set.
- R8: Command 7Fh is a RAM burst write. It stores every complete byte starting at location 0 and stops after location 30, with no wrap. Command FFh is a RAM burst read. It streams locations 0 to 30, then zeros.
- R9: A single RAM access uses command {r,1,a[4:0],1} for locations a = 0..30.
- R10: Control register bit 7 (register 7, commands 0Fh/8Fh) is write protect, and control reads return {wp,0000000}. The value of write protect at command time blocks RAM writes, staged time writes and external register writes. The control register itself stays writable, both by a single write and by the last byte of a full clock burst.
- R11: Register addresses other than 0..7, 9 and 31 go to the external port. A write gives a one-cycle `reg_wr` pulse with `reg_addr` and `reg_wdata`. A read returns `reg_rdata` for the address on `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output drive enable for `miso` |
| tk_cur | input | 64 | Live counters, byte 0 seconds through byte 6 year, byte 7 century |
| tk_inc | input | 1 | High while the counters take a seconds increment |
| tk_load | output | 1 | Load staged values into the counters |
| tk_load_mask | output | 8 | Which counter bytes to load |
| tk_load_data | output | 64 | Staged counter bytes, same layout as `tk_cur` |
| reg_addr | output | 5 | External register address |
| reg_wr | output | 1 | External register write pulse |
| reg_wdata | output | 8 | External register write data |
| reg_rdata | input | 8 | External register read data |

## Verification
The bench goes after the commit rules. It runs a clock burst cut at seven bytes, a full burst followed by a stray partial byte, and a single write ended mid-byte. A design that loaded staged data too eagerly would emit a `tk_load` in each of these cases. It also holds `tk_inc` high across a chip-select rise and across the end of a read command. In that window the counters change and then change again, so a design that ignores the increment would load or snapshot at the wrong moment and return the stale or the later value. The RAM burst is written past location 30 and cut inside a byte, which exposes address wrap and partial-byte stores. The protect flag is checked against every write path, including a burst whose control byte must still clear it.

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs #(
  parameter int RAM_DEPTH = 31,
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        miso_oe,
  input  logic [63:0] tk_cur,
  input  logic        tk_inc,
  output logic        tk_load,
  output logic [7:0]  tk_load_mask,
  output logic [63:0] tk_load_data,
  output logic [4:0]  reg_addr,
  output logic        reg_wr,
  output logic [7:0]  reg_wdata,
  input  logic [7:0]  reg_rdata
);
  localparam logic [5:0] RAM_N   = 6'(RAM_DEPTH);
  localparam logic [4:0] BURST_A = 5'h1F;
  localparam logic [4:0] CTL_A   = 5'd7;
  localparam logic [4:0] CEN_A   = 5'd9;

  logic [SYNC:0]   cs_sr, sck_sr;
  logic [SYNC-1:0] mosi_sr;
  logic [6:0]  sh_in;
  logic [7:0]  sh_out, cmd, nxt_out;
  logic [2:0]  bit_cnt;
  logic [5:0]  idx;
  logic        cmd_done, wp, wp_lock, snap_pend, commit_pend, ctl_stage, ctl_pend;
  logic [63:0] snap, stage;
  logic [7:0]  stage_mask;
  logic [7:0]  ram [RAM_DEPTH];

  wire cs_act   = ~cs_sr[SYNC-1];
  wire cs_rise  = cs_sr[SYNC:SYNC-1] == 2'b01;
  wire sck_rise = cs_act && sck_sr[SYNC:SYNC-1] == 2'b01;
  wire sck_fall = cs_act && sck_sr[SYNC:SYNC-1] == 2'b10;
  wire [7:0] byte_in = {sh_in, mosi_sr[SYNC-1]};
  wire byte_end  = sck_rise && bit_cnt == 3'd7;
  wire data_byte = byte_end && cmd_done;

  wire       is_rd   = cmd[7];
  wire       is_ram  = cmd[6];
  wire [4:0] addr    = cmd[5:1];
  wire       burst   = addr == BURST_A;
  wire       wr_ok   = cmd_done && !cmd[7] && cmd[0];
  wire       tk_addr = addr < 5'd7 || addr == CEN_A;
  wire [2:0] slot    = (addr == CEN_A) ? 3'd7 : addr[2:0];
  wire       ext_addr = !burst && !tk_addr && addr != CTL_A;
  wire [7:0] ctl_rd  = {wp, 7'b0};
  wire       idx0    = idx == 6'd0;

  wire ram_we = data_byte && wr_ok && is_ram && !wp_lock &&
                (burst ? idx < RAM_N : (idx0 && {1'b0, addr} < RAM_N));
  wire [4:0] ram_wa = burst ? idx[4:0] : addr;
  wire tk_we  = data_byte && wr_ok && !is_ram && !wp_lock &&
                (burst ? idx < 6'd7 : (idx0 && tk_addr));
  wire [2:0] tk_ws = burst ? idx[2:0] : slot;
  wire ctl_we    = data_byte && wr_ok && !is_ram && !burst && idx0 && addr == CTL_A;
  wire burst_ctl = data_byte && wr_ok && !is_ram && burst && idx == 6'd7;
  wire ext_we    = data_byte && wr_ok && !is_ram && ext_addr && idx0 && !wp_lock;
  wire commit_ok = wr_ok && !is_ram && bit_cnt == 3'd0 &&
                   (burst ? idx >= 6'd8 : idx >= 6'd1);

  assign miso         = sh_out[7] & cs_act;
  assign miso_oe      = cs_act;
  assign tk_load      = commit_pend & ~tk_inc;
  assign tk_load_mask = stage_mask;
  assign tk_load_data = stage;
  assign reg_addr     = addr;

  always_comb begin
    nxt_out = 8'h00;
    if (is_rd) begin
      if (is_ram) begin
        if (burst) begin
          if (idx < RAM_N) nxt_out = ram[idx[4:0]];
        end else if (idx0 && {1'b0, addr} < RAM_N) begin
          nxt_out = ram[addr];
        end
      end else if (burst) begin
        if (idx < 6'd7) nxt_out = snap[{idx[2:0], 3'b000} +: 8];
        else if (idx == 6'd7) nxt_out = ctl_rd;
      end else if (idx0) begin
        if (tk_addr) nxt_out = snap[{slot, 3'b000} +: 8];
        else if (addr == CTL_A) nxt_out = ctl_rd;
        else nxt_out = reg_rdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ram_we) ram[ram_wa] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr       <= '1;
      sck_sr      <= '0;
      mosi_sr     <= '0;
      sh_in       <= '0;
      sh_out      <= '0;
      cmd         <= '0;
      bit_cnt     <= '0;
      idx         <= '0;
      cmd_done    <= 1'b0;
      wp          <= 1'b0;
      wp_lock     <= 1'b0;
      snap_pend   <= 1'b0;
      commit_pend <= 1'b0;
      ctl_stage   <= 1'b0;
      ctl_pend    <= 1'b0;
      snap        <= '0;
      stage       <= '0;
      stage_mask  <= '0;
      reg_wr      <= 1'b0;
      reg_wdata   <= '0;
    end else begin
      cs_sr   <= {cs_sr[SYNC-1:0], cs_n};
      sck_sr  <= {sck_sr[SYNC-1:0], sclk};
      mosi_sr <= {mosi_sr[SYNC-2:0], mosi};
      reg_wr  <= ext_we;
      if (ext_we) reg_wdata <= byte_in;
      if (snap_pend && !tk_inc) begin
        snap      <= tk_cur;
        snap_pend <= 1'b0;
      end
      if (tk_load) commit_pend <= 1'b0;
      if (tk_we) begin
        stage[{tk_ws, 3'b000} +: 8] <= byte_in;
        stage_mask[tk_ws] <= 1'b1;
      end
      if (ctl_we) wp <= byte_in[7];
      if (burst_ctl) begin
        ctl_stage <= byte_in[7];
        ctl_pend  <= 1'b1;
      end
      if (cs_rise && commit_ok) begin
        if (|stage_mask) commit_pend <= 1'b1;
        if (ctl_pend) wp <= ctl_stage;
      end
      if (!cs_act) begin
        bit_cnt  <= '0;
        idx      <= '0;
        cmd_done <= 1'b0;
        sh_out   <= '0;
        ctl_pend <= 1'b0;
      end else begin
        if (sck_rise) begin
          sh_in   <= byte_in[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (byte_end) begin
            if (!cmd_done) begin
              cmd        <= byte_in;
              cmd_done   <= 1'b1;
              wp_lock    <= wp;
              stage_mask <= '0;
              if (byte_in[7] && !byte_in[6]) snap_pend <= 1'b1;
            end else if (idx != 6'h3F) begin
              idx <= idx + 6'd1;
            end
          end
        end
        if (sck_fall)
          sh_out <= (bit_cnt == 3'd0 && cmd_done) ? nxt_out : {sh_out[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/rtc_spi_regs_chk.sv
module rtc_spi_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso,
  input logic       miso_oe,
  input logic       tk_inc,
  input logic       tk_load,
  input logic [7:0] tk_load_mask,
  input logic       reg_wr,
  input logic       wp
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n, 3) && $past(cs_n, 2) && $past(cs_n) && cs_n) |-> (!miso && !miso_oe));

  p_load_no_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tk_inc |-> !tk_load);

  p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tk_load |=> !tk_load);

  p_load_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tk_load |-> (tk_load_mask != 8'h00));

  p_load_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tk_load |-> cs_n);

  p_reg_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_reg_wr_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !wp);
endmodule

bind rtc_spi_regs rtc_spi_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .miso_oe(miso_oe),
  .tk_inc(tk_inc), .tk_load(tk_load), .tk_load_mask(tk_load_mask),
  .reg_wr(reg_wr), .wp(wp)
);

// File: tb/rtc_spi_regs_bench.sv
module rtc_spi_regs_bench;
  localparam int H = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, tk_inc = 1'b0;
  logic [63:0] tk_cur = '0;
  logic miso, miso_oe, tk_load, reg_wr;
  logic [7:0] tk_load_mask, reg_wdata, reg_rdata;
  logic [63:0] tk_load_data;
  logic [4:0] reg_addr;

  always #2 clk = ~clk;
  assign reg_rdata = {3'b101, reg_addr};

  rtc_spi_regs u_rtc_spi_regs (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .tk_cur(tk_cur), .tk_inc(tk_inc),
    .tk_load(tk_load), .tk_load_mask(tk_load_mask), .tk_load_data(tk_load_data),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int tests = 0, fails = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] wbuf [40];
  logic mon_arm = 1'b0;
  logic [7:0] mon_sh = '0;
  int mon_n = 0;
  int ld_cnt = 0, rw_cnt = 0;
  logic [7:0] ld_mask = '0, rw_data = '0;
  logic [63:0] ld_data = '0;
  logic [4:0] rw_addr = '0;

  task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, a, e);
    end
  endtask

  task automatic exp(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    if (tk_load) begin ld_cnt++; ld_mask = tk_load_mask; ld_data = tk_load_data; end
    if (reg_wr) begin rw_cnt++; rw_addr = reg_addr; rw_data = reg_wdata; end
  end

  always @(posedge sclk) begin
    if (mon_arm) begin
      mon_sh = {mon_sh[6:0], miso};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected read byte actual %h expected none", mon_sh);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (mon_sh !== e) begin
            fails++;
            $display("FAIL %s read actual %h expected %h", t, mon_sh, e);
          end
        end
      end
    end
  end

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = b[i];
      half(); sclk = 1'b1;
      half(); sclk = 1'b0;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0; half();
  endtask

  task automatic cs_off();
    half(); cs_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] c, input int n, input int tail);
    cs_on();
    send(c, 8);
    for (int i = 0; i < n; i++) send(wbuf[i], 8);
    if (tail > 0) send(8'hFF, tail);
    cs_off();
  endtask

  task automatic rd(input logic [7:0] c, input int n);
    cs_on();
    send(c, 8);
    chk("R1 oe low-cs", 64'(miso_oe), 64'd1);
    mon_arm = 1'b1;
    for (int i = 0; i < n; i++) send(8'h00, 8);
    mon_arm = 1'b0;
    cs_off();
    chk("R1 oe idle", 64'({miso_oe, miso}), 64'd0);
  endtask

  task automatic wr1(input logic [7:0] c, input logic [7:0] d);
    wbuf[0] = d;
    wr(c, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c0;
    repeat (10) @(negedge clk);
    chk("R1 reset miso/oe", 64'({miso, miso_oe}), 64'd0);
    chk("R6 reset load", 64'({tk_load, reg_wr}), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 full RAM burst, extra byte must not wrap
    for (int i = 0; i < 31; i++) wbuf[i] = 8'(i * 7 + 3);
    wbuf[31] = 8'hEE;
    wr(8'h7F, 32, 0);
    for (int i = 0; i < 31; i++) exp(8'(i * 7 + 3), "R8 burst read");
    exp(8'h00, "R8 past end");
    rd(8'hFF, 32);
    // R8 partial burst keeps complete bytes only
    wbuf[0] = 8'h90; wbuf[1] = 8'h91;
    wr(8'h7F, 2, 5);
    exp(8'h90, "R8 partial 0"); exp(8'h91, "R8 partial 1"); exp(8'(2 * 7 + 3), "R8 partial 2");
    rd(8'hFF, 3);

    // R9 single RAM
    wr1(8'h4B, 8'hA5);
    exp(8'hA5, "R9 single ram"); rd(8'hCB, 1);

    // R2 bit0 clear blocks writes
    wr1(8'h4A, 8'h00);
    exp(8'hA5, "R2 ram"); rd(8'hCB, 1);
    c0 = ld_cnt;
    wr1(8'h02, 8'h12);
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h11;
    wr(8'h3E, 8, 0);
    chk("R2 no load", 64'(ld_cnt), 64'(c0));

    // R3 clock burst write
    wbuf[0] = 8'h31; wbuf[1] = 8'h11; wbuf[2] = 8'hB0; wbuf[3] = 8'h04;
    wbuf[4] = 8'h07; wbuf[5] = 8'h05; wbuf[6] = 8'h02; wbuf[7] = 8'h00;
    c0 = ld_cnt;
    wr(8'h3F, 8, 0);
    chk("R3 load count", 64'(ld_cnt), 64'(c0 + 1));
    chk("R3 load mask", 64'(ld_mask), 64'h7F);
    chk("R3 load data", ld_data[55:0], 64'h02_05_07_04_B0_11_31);
    c0 = ld_cnt;
    wr(8'h3F, 7, 0);
    chk("R3 short burst", 64'(ld_cnt), 64'(c0));
    wr(8'h3F, 8, 3);
    chk("R3 trailing partial", 64'(ld_cnt), 64'(c0));

    // R4 clock burst read
    tk_cur = 64'h20_99_06_12_31_23_59_58;
    exp(8'h58, "R4 sec"); exp(8'h59, "R4 min"); exp(8'h23, "R4 hr"); exp(8'h31, "R4 date");
    exp(8'h12, "R4 mon"); exp(8'h06, "R4 day"); exp(8'h99, "R4 yr"); exp(8'h00, "R4 ctl");
    exp(8'h00, "R4 past end");
    rd(8'hBF, 9);

    // R5 snapshot waits for increment
    tk_cur = 64'h20_99_06_12_31_23_59_40;
    tk_inc = 1'b1;
    exp(8'h41, "R5 snapshot");
    fork
      rd(8'h81, 1);
      begin
        repeat (8) @(posedge sclk);
        repeat (5) @(negedge clk); tk_cur[7:0] = 8'h41;
        @(negedge clk); tk_inc = 1'b0;
        repeat (3) @(negedge clk); tk_cur[7:0] = 8'h42;
      end
    join

    // R6 load waits for increment
    c0 = ld_cnt;
    tk_inc = 1'b1;
    wr1(8'h03, 8'h45);
    repeat (30) @(negedge clk);
    chk("R6 held off", 64'(ld_cnt), 64'(c0));
    tk_inc = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6 released", 64'(ld_cnt), 64'(c0 + 1));
    chk("R6 mask", 64'(ld_mask), 64'h02);
    chk("R6 data", 64'(ld_data[15:8]), 64'h45);

    // R7 single timekeeping writes
    c0 = ld_cnt;
    wr1(8'h13, 8'h20);
    chk("R7 century count", 64'(ld_cnt), 64'(c0 + 1));
    chk("R7 century mask", 64'(ld_mask), 64'h80);
    chk("R7 century data", 64'(ld_data[63:56]), 64'h20);
    c0 = ld_cnt;
    wr(8'h01, 0, 4);
    chk("R7 partial", 64'(ld_cnt), 64'(c0));
    wr1(8'h01, 8'h17);
    chk("R7 sec mask", 64'(ld_mask), 64'h01);
    chk("R7 sec data", 64'(ld_data[7:0]), 64'h17);

    // R11 external port
    c0 = rw_cnt;
    wr1(8'h15, 8'h5A);
    chk("R11 wr count", 64'(rw_cnt), 64'(c0 + 1));
    chk("R11 wr addr/data", 64'({rw_addr, rw_data}), 64'({5'd10, 8'h5A}));
    exp(8'hAA, "R11 read"); rd(8'h95, 1);

    // R10 write protect
    wr1(8'h0F, 8'hFF);
    exp(8'h80, "R10 ctl read"); rd(8'h8F, 1);
    wr1(8'h4B, 8'h3C);
    exp(8'hA5, "R10 ram blocked"); rd(8'hCB, 1);
    c0 = ld_cnt;
    wr1(8'h01, 8'h33);
    chk("R10 tk blocked", 64'(ld_cnt), 64'(c0));
    c0 = rw_cnt;
    wr1(8'h15, 8'h77);
    chk("R10 ext blocked", 64'(rw_cnt), 64'(c0));
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h00;
    c0 = ld_cnt;
    wr(8'h3F, 8, 0);
    chk("R10 burst tk blocked", 64'(ld_cnt), 64'(c0));
    exp(8'h00, "R10 burst clears wp"); rd(8'h8F, 1);
    wr1(8'h4B, 8'h3C);
    exp(8'h3C, "R10 ram unlocked"); rd(8'hCB, 1);

    repeat (20) @(negedge clk);
    chk("R1 all reads consumed", 64'(exp_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule